// File: doc/BRIEF.md
# Card Station Pipeline Controller

This block sequences a card unit in which three cards can sit on the path at once: a pre-read station, a punch station and a post-read station, after which each card falls into one of two stackers. The processor fills a punch buffer; the moment that load completes, the unit starts one card cycle by itself. In that cycle it punches the buffer into the card at the punch station, samples the images at both read stations, pulls a new card from the magazine while moving every card one place on, and finally sends the card that left the post-read station to the stacker chosen by the program.

The block keeps one occupancy bit per station, so an empty station is neither punched nor sampled. A card punched in one cycle reaches the post-read station and is sampled in the next cycle. Its image is then compared, hole by hole, with a copy of the data punched into it, and the result is reported as a punch-check flag. The motors, the punch mechanics and the hole sensing belong to other blocks.

Top module: `card_station_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is idle (`busy`=0). All stations are empty (`occ`=0), and `punchFire`, `chkValid`, `chkErr` and `dropValid` are 0.
- R2: A `bufLoadDone` pulse while idle stores `punchData` in the punch buffer and starts a card cycle on the next clock. A pulse while busy is ignored, and `punchOut` keeps the stored value.
- R3: The steps run in a fixed order, one clock after another: punch one clock after the load, sense one clock after that, advance one clock after that, then a stacker window of `STACK_WAIT` clocks.
- R4: `punchFire` is high for the single punch clock, and only when the punch station (`occ[1]`) holds a card. `punchOut` always shows the punch buffer.
- R5: At the end of the sense clock, `preImage` takes `preReadData` only if the pre-read station (`occ[0]`) is occupied, and `postImage` takes `postReadData` only if the post-read station (`occ[2]`) is occupied. An image whose station is empty keeps its value.
- R6: At the end of the advance clock, `occ` becomes {`occ[1]`, `occ[0]`, `feedAvail`}: bit 0 is pre-read, bit 1 is punch and bit 2 is post-read. `occ` does not change outside the advance clock.
- R7: When a card that was punched in the previous cycle is sensed at post-read, `chkValid` pulses for one clock right after the sense clock. `chkErr` is 1 exactly when `postReadData` differs from the data punched into that card. At all other times both are 0.
- R8: On the last clock of the stacker window, `dropValid` is 1 if a card left the post-read station at the advance. `dropBin` gives the most recent `stackSel` presented with `stackSelValid` during this cycle, or 0 (stacker 0) if none was presented. A selection made while idle has no effect.
- R9: `busy` stays high for exactly 3+`STACK_WAIT` clocks per cycle. It is low on the clock after the drop slot, and a new load is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufLoadDone | input | 1 | Punch buffer load complete; starts a cycle |
| punchData | input | DATA_W | Data written into the punch buffer |
| feedAvail | input | 1 | Magazine supplies a card at the advance |
| preReadData | input | DATA_W | Hole image sensed at the pre-read station |
| postReadData | input | DATA_W | Hole image sensed at the post-read station |
| stackSelValid | input | 1 | Stacker selection present |
| stackSel | input | 1 | Chosen stacker, 0 or 1 |
| busy | output | 1 | A card cycle is in progress |
| punchFire | output | 1 | Punch the card at the punch station now |
| punchOut | output | DATA_W | Punch buffer contents |
| preImage | output | DATA_W | Last pre-read image |
| postImage | output | DATA_W | Last post-read image |
| occ | output | 3 | Station occupancy (0 pre-read, 1 punch, 2 post-read) |
| chkValid | output | 1 | Punch-check result present |
| chkErr | output | 1 | Post-read image differs from punched data |
| dropValid | output | 1 | Card released to a stacker now |
| dropBin | output | 1 | Stacker receiving the card |

## Verification
Counting from the clock edge that samples a load, `punchFire` is due one clock later. The images, `chkValid` and `chkErr` are due after the second edge, the new `occ` after the third, and `dropValid` and `dropBin` after edge 2+`STACK_WAIT`; `busy` falls after edge 3+`STACK_WAIT`. The bench drives inputs and samples outputs on falling edges, and counts falling edges from the load to reach each slot exactly. It keeps its own model of the occupancy, of the punched data carried with each card and of the last images. It sweeps feed patterns that fill and drain the path, post-read corruption, and four stacker-selection patterns.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int NUM_STATIONS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUNCH,
    ST_SENSE,
    ST_ADVANCE,
    ST_STACK
  } phaseT;

  typedef struct packed {
    logic active;
    logic loadBuf;
    logic doPunch;
    logic doSense;
    logic doAdvance;
    logic doStack;
  } strobeT;

endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
#(
  parameter int STACK_WAIT = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bufLoadDone,
  output strobeT stb
);

  localparam int CNT_W = (STACK_WAIT > 1) ? $clog2(STACK_WAIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STACK_WAIT - 1);

  phaseT phase;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      case (phase)
        ST_IDLE:    if (bufLoadDone) phase <= ST_PUNCH;
        ST_PUNCH:   phase <= ST_SENSE;
        ST_SENSE:   phase <= ST_ADVANCE;
        ST_ADVANCE: begin
          phase   <= ST_STACK;
          waitCnt <= '0;
        end
        ST_STACK: begin
          if (waitCnt == CNT_LAST) phase <= ST_IDLE;
          else waitCnt <= waitCnt + 1'b1;
        end
        default:    phase <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.active    = (phase != ST_IDLE);
    stb.loadBuf   = (phase == ST_IDLE) && bufLoadDone;
    stb.doPunch   = (phase == ST_PUNCH);
    stb.doSense   = (phase == ST_SENSE);
    stb.doAdvance = (phase == ST_ADVANCE);
    stb.doStack   = (phase == ST_STACK) && (waitCnt == CNT_LAST);
  end

endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int DATA_W = 90
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  stb,
  input  logic [DATA_W-1:0]       punchData,
  input  logic                    feedAvail,
  input  logic [DATA_W-1:0]       preReadData,
  input  logic [DATA_W-1:0]       postReadData,
  input  logic                    stackSelValid,
  input  logic                    stackSel,
  output logic                    punchFire,
  output logic [DATA_W-1:0]       punchOut,
  output logic [DATA_W-1:0]       preImage,
  output logic [DATA_W-1:0]       postImage,
  output logic [NUM_STATIONS-1:0] occ,
  output logic                    chkValid,
  output logic                    chkErr,
  output logic                    dropValid,
  output logic                    dropBin
);

  logic [DATA_W-1:0]       bufReg;
  logic [DATA_W-1:0]       postCopy;
  logic                    postPunched;
  logic [NUM_STATIONS-1:0] occReg;
  logic                    ejected;
  logic                    selReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg      <= '0;
      postCopy    <= '0;
      postPunched <= 1'b0;
      occReg      <= '0;
      ejected     <= 1'b0;
      selReg      <= 1'b0;
      preImage    <= '0;
      postImage   <= '0;
      chkValid    <= 1'b0;
      chkErr      <= 1'b0;
    end else begin
      if (stb.loadBuf) begin
        bufReg <= punchData;
        selReg <= 1'b0;
      end else if (stb.active && stackSelValid) begin
        selReg <= stackSel;
      end

      chkValid <= 1'b0;
      chkErr   <= 1'b0;
      if (stb.doSense) begin
        if (occReg[0]) preImage  <= preReadData;
        if (occReg[2]) postImage <= postReadData;
        if (occReg[2] && postPunched) begin
          chkValid <= 1'b1;
          chkErr   <= (postReadData != postCopy);
        end
      end

      if (stb.doAdvance) begin
        ejected     <= occReg[NUM_STATIONS-1];
        postPunched <= occReg[1];
        postCopy    <= bufReg;
        occReg      <= {occReg[NUM_STATIONS-2:0], feedAvail};
      end
    end
  end

  assign punchFire = stb.doPunch && occReg[1];
  assign punchOut  = bufReg;
  assign occ       = occReg;
  assign dropValid = stb.doStack && ejected;
  assign dropBin   = (stb.active && stackSelValid) ? stackSel : selReg;

endmodule

// File: rtl/card_station_ctrl.sv
module card_station_ctrl
  import csc_pkg::*;
#(
  parameter int DATA_W     = 90,
  parameter int STACK_WAIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufLoadDone,
  input  logic [DATA_W-1:0] punchData,
  input  logic              feedAvail,
  input  logic [DATA_W-1:0] preReadData,
  input  logic [DATA_W-1:0] postReadData,
  input  logic              stackSelValid,
  input  logic              stackSel,
  output logic              busy,
  output logic              punchFire,
  output logic [DATA_W-1:0] punchOut,
  output logic [DATA_W-1:0] preImage,
  output logic [DATA_W-1:0] postImage,
  output logic [2:0]        occ,
  output logic              chkValid,
  output logic              chkErr,
  output logic              dropValid,
  output logic              dropBin
);

  strobeT stb;

  csc_ctrl #(.STACK_WAIT(STACK_WAIT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bufLoadDone(bufLoadDone),
    .stb        (stb)
  );

  csc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .punchData    (punchData),
    .feedAvail    (feedAvail),
    .preReadData  (preReadData),
    .postReadData (postReadData),
    .stackSelValid(stackSelValid),
    .stackSel     (stackSel),
    .punchFire    (punchFire),
    .punchOut     (punchOut),
    .preImage     (preImage),
    .postImage    (postImage),
    .occ          (occ),
    .chkValid     (chkValid),
    .chkErr       (chkErr),
    .dropValid    (dropValid),
    .dropBin      (dropBin)
  );

  assign busy = stb.active;

endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int DATA_W = 90
) (
  input logic              clk,
  input logic              rstN,
  input logic              bufLoadDone,
  input logic              busy,
  input logic              punchFire,
  input logic [DATA_W-1:0] punchOut,
  input logic [2:0]        occ,
  input logic              chkValid,
  input logic              chkErr,
  input logic              dropValid
);

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && bufLoadDone) |=> busy) else $error("AST_LOAD_STARTS"); // R2

  AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(punchOut)) else $error("AST_BUF_HELD"); // R2

  AST_PUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    punchFire |=> !punchFire) else $error("AST_PUNCH_SINGLE"); // R3

  AST_OCC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(occ)) else $error("AST_OCC_IDLE"); // R6

  AST_CHK_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    chkErr |-> chkValid) else $error("AST_CHK_QUALIFIED"); // R7

  AST_CHK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> !chkValid) else $error("AST_CHK_PULSE"); // R7

  AST_DROP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    dropValid |=> !busy) else $error("AST_DROP_ENDS"); // R9

endmodule

bind card_station_ctrl csc_checker #(.DATA_W(DATA_W)) u_csc_checker (
  .clk        (clk),
  .rstN       (rstN),
  .bufLoadDone(bufLoadDone),
  .busy       (busy),
  .punchFire  (punchFire),
  .punchOut   (punchOut),
  .occ        (occ),
  .chkValid   (chkValid),
  .chkErr     (chkErr),
  .dropValid  (dropValid)
);

// File: tb/card_station_ctrl_bench.sv
module card_station_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int SW         = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          bufLoadDone;
  logic [DW-1:0] punchData;
  logic          feedAvail;
  logic [DW-1:0] preReadData;
  logic [DW-1:0] postReadData;
  logic          stackSelValid;
  logic          stackSel;
  logic          busy, punchFire, chkValid, chkErr, dropValid, dropBin;
  logic [DW-1:0] punchOut, preImage, postImage;
  logic [2:0]    occ;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_station_ctrl #(.DATA_W(DW), .STACK_WAIT(SW)) u_card_station_ctrl (
    .clk(clk), .rstN(rstN), .bufLoadDone(bufLoadDone), .punchData(punchData),
    .feedAvail(feedAvail), .preReadData(preReadData), .postReadData(postReadData),
    .stackSelValid(stackSelValid), .stackSel(stackSel), .busy(busy),
    .punchFire(punchFire), .punchOut(punchOut), .preImage(preImage),
    .postImage(postImage), .occ(occ), .chkValid(chkValid), .chkErr(chkErr),
    .dropValid(dropValid), .dropBin(dropBin)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench model
  logic [2:0]    mOcc     = '0;
  logic          mPunched = 1'b0;
  logic [DW-1:0] mCopy    = '0;
  logic [DW-1:0] mPre     = '0;
  logic [DW-1:0] mPost    = '0;

  initial begin
    rstN = 1'b0; bufLoadDone = 1'b0; punchData = '0; feedAvail = 1'b0;
    preReadData = '0; postReadData = '0; stackSelValid = 1'b0; stackSel = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", 32'(busy), 0);
    check("R1", "occ in reset", 32'(occ), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "occ", 32'(occ), 0);
    check("R1", "punchFire", 32'(punchFire), 0);
    check("R1", "chkValid/chkErr", 32'({chkValid, chkErr}), 0);
    check("R1", "dropValid", 32'(dropValid), 0);

    for (int i = 0; i < 24; i++) begin
      logic [DW-1:0] d, pv;
      logic corrupt, ej, expChk;
      int mode;
      d       = DW'(i * 37 + 5);
      pv      = DW'(i * 11 + 3);
      corrupt = (i % 4 == 3);
      mode    = i % 4;
      feedAvail = (i < 18) && (i % 5 != 1);

      if (mode == 0) begin  // R8: selection while idle must be ignored
        stackSelValid = 1'b1; stackSel = 1'b1;
        @(negedge clk);
        stackSelValid = 1'b0;
      end

      bufLoadDone = 1'b1; punchData = d;
      @(negedge clk);  // punch clock
      bufLoadDone = 1'b0;
      check("R3", "busy at punch", 32'(busy), 1);
      check("R4", "punchFire", 32'(punchFire), 32'(mOcc[1]));
      check("R4", "punchOut", 32'(punchOut), 32'(d));
      bufLoadDone  = 1'b1; punchData = ~d;  // R2: load while busy
      preReadData  = pv;
      postReadData = corrupt ? (mCopy ^ DW'(8'h10)) : mCopy;

      @(negedge clk);  // sense clock
      bufLoadDone = 1'b0;
      check("R2", "punchOut after busy load", 32'(punchOut), 32'(d));
      check("R3", "punchFire off at sense", 32'(punchFire), 0);
      if (mode == 1 || mode == 2) begin stackSelValid = 1'b1; stackSel = 1'b1; end

      @(negedge clk);  // advance clock
      stackSelValid = 1'b0;
      if (mOcc[0]) mPre = pv;
      if (mOcc[2]) mPost = postReadData;
      expChk = mOcc[2] && mPunched;
      check("R5", "preImage", 32'(preImage), 32'(mPre));
      check("R5", "postImage", 32'(postImage), 32'(mPost));
      check("R7", "chkValid", 32'(chkValid), 32'(expChk));
      check("R7", "chkErr", 32'(chkErr), 32'(expChk && corrupt));
      check("R6", "occ before advance", 32'(occ), 32'(mOcc));
      ej       = mOcc[2];
      mPunched = mOcc[1];
      mCopy    = d;
      mOcc     = {mOcc[1:0], feedAvail};

      @(negedge clk);  // first stacker-window clock
      check("R6", "occ after advance", 32'(occ), 32'(mOcc));
      check("R7", "chkValid one clock", 32'(chkValid), 0);
      repeat (SW - 2) @(negedge clk);
      if (mode == 2) begin stackSelValid = 1'b1; stackSel = 1'b0; end
      if (mode == 3) begin stackSelValid = 1'b1; stackSel = 1'b1; end

      @(negedge clk);  // drop slot
      check("R8", "dropValid", 32'(dropValid), 32'(ej));
      if (ej) check("R8", "dropBin", 32'(dropBin), (mode == 0 || mode == 2) ? 0 : 1);
      check("R9", "busy in drop slot", 32'(busy), 1);
      stackSelValid = 1'b0;

      @(negedge clk);
      check("R9", "busy after cycle", 32'(busy), 0);
      check("R8", "dropValid after cycle", 32'(dropValid), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule